// File: doc/BRIEF.md
# Multi-Channel Down-Counting Event Timer

This block is a register-mapped timer with a parameterised number of independent 32-bit channels that count downward. Each channel has a control word, an interval (reload) value and a live count that software can read. It runs either periodically, reloading from its interval each time it expires, or as a one-shot that stops at zero. A common tick enable drives every channel. Each channel divides that tick by a power of two chosen in its control word. A clock-source code is kept in the control word and read back, but it does not change which tick drives the channel.

Every channel that expires raises a pending bit in a shared status word, and software clears that bit by writing a one to it. A shared enable word masks the pending bits onto a single interrupt line. A channel whose enable is cleared does not stop at once. It keeps counting for two more raw ticks and then freezes. Software allows for this by programming one-shot intervals shorter than the delay it wants. A periodic channel with an all-ones interval and no interrupt enabled serves as a wrapping time base.

Top module: `evt_timer_top`

## Requirements
- R1: After reset every register reads zero, every channel is idle and `irq` is low.
- R2: Word addresses: interrupt enable at 0x00 and status at 0x04, where bit n belongs to channel n. Channel n has its control word at 0x10*n+0x10, its interval at 0x10*n+0x14 and its count at 0x10*n+0x18. Control bits: 0 enable, 1 reload, 3:2 clock source, 6:4 prescale, 7 one-shot (0 = periodic). Bits above the defined fields read as zero.
- R3: A control write with enable and reload set loads the interval into the count on the channel's next divided tick. The reload bit reads 1 until that tick and 0 after it.
- R4: In periodic mode each divided tick lowers the count by one. A divided tick that finds the count at zero loads the interval, so the period is interval+1 divided ticks.
- R5: In one-shot mode the count stays at zero after it reaches zero, and no further status is raised until the channel is reloaded.
- R6: A prescale value p gives one divided tick for every 2^p raw ticks, counted from the moment the channel becomes active.
- R7: A channel's status bit sets on the divided tick that leaves its count at zero, including a reload of a zero interval. Writing 1 to a status bit clears it. Writing 0 has no effect. A set and a clear in the same cycle leave the bit set.
- R8: `irq` is high exactly when some channel has both its status bit and its enable bit set.
- R9: After enable is cleared, the channel still acts on the next two raw ticks and then holds its count.
- R10: The clock-source field is stored and read back, and it does not affect counting.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd`. It is zero for unmapped addresses. Writes to count registers and unmapped addresses change nothing.
- R12: Channels count, divide and raise status independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Common raw timer tick, one-cycle enable |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach is a status write that clears a bit in the very cycle the channel expires and sets it. The bench brings a one-shot channel down to a count of one, then drives the tick and a clear write to the status word on the same edge. The two-tick drain after disable is also awkward, because it depends on prescaler phase. The stimulus uses a fresh channel with division one, disables it at a known count, and reads the count after each following tick. The main sweep runs across several intervals, including zero, and across several prescale values. It reads the count just before and just after every divided tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PRE_W = 3;

  // control word, bit 7 down to bit 0
  typedef struct packed {
    logic             oneshot;
    logic [PRE_W-1:0] pre;
    logic [1:0]       src;
    logic             reload;
    logic             en;
  } ctrl_t;

  localparam logic [3:0] OFF_IE   = 4'h0;
  localparam logic [3:0] OFF_ST   = 4'h4;
  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_IVAL = 4'h4;
  localparam logic [3:0] OFF_CNT  = 4'h8;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [PRE_W-1:0] sel,
  output logic             pulse
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div_q, div_d, mask;

  always_comb begin
    mask  = ~({DIV_W{1'b1}} << sel);
    pulse = tick & run & ((div_q & mask) == mask);
    if (!run)      div_d = '0;
    else if (tick) div_d = div_q + DIV_W'(1);
    else           div_d = div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              div_q <= '0;
    else if (tick || !run)   div_q <= div_d;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W       = 32,
  parameter int PRE_W       = 3,
  parameter int DRAIN_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             reload,
  input  logic             oneshot,
  input  logic [PRE_W-1:0] pre,
  input  logic [CNT_W-1:0] interval,
  output logic [CNT_W-1:0] cnt,
  output logic             act,
  output logic             ctick,
  output logic             hit,
  output logic             rld_done
);
  localparam int DR_W = $clog2(DRAIN_TICKS + 1);

  logic             act_q, act_d;
  logic [DR_W-1:0]  dr_q, dr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign act = en | act_q;
  assign cnt = cnt_q;

  tmr_prescale #(.PRE_W(PRE_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(act), .sel(pre), .pulse(ctick)
  );

  // count next state
  always_comb begin
    cnt_d    = cnt_q;
    hit      = 1'b0;
    rld_done = 1'b0;
    if (ctick) begin
      if (reload) begin
        cnt_d    = interval;
        hit      = (interval == '0);
        rld_done = 1'b1;
      end else if (cnt_q == '0) begin
        if (!oneshot) begin
          cnt_d = interval;
          hit   = (interval == '0);
        end
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
        hit   = (cnt_q == CNT_W'(1));
      end
    end
  end

  // drain after disable: the channel lives on for DRAIN_TICKS raw ticks
  always_comb begin
    act_d = act_q;
    dr_d  = dr_q;
    if (en) begin
      act_d = 1'b1;
      dr_d  = '0;
    end else if (act_q && tick) begin
      if (dr_q == DR_W'(DRAIN_TICKS - 1)) begin
        act_d = 1'b0;
        dr_d  = '0;
      end else begin
        dr_d = dr_q + DR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      dr_q  <= '0;
    end else begin
      act_q <= act_d;
      dr_q  <= dr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (ctick) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/evt_timer_top.sv
module evt_timer_top
  import tmr_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int CNT_W       = 32,
  parameter int ADDR_W      = 8,
  parameter int DRAIN_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam int PG_W = ADDR_W - 4;

  ctrl_t [NUM_CH-1:0]            ctrl_q, ctrl_d;
  logic  [NUM_CH-1:0][CNT_W-1:0] ival_q, ival_d;
  logic  [NUM_CH-1:0][CNT_W-1:0] cnt_w;
  logic  [NUM_CH-1:0]            act_w, ctick_w, hit_w, rld_w;
  logic  [NUM_CH-1:0]            ie_q, ie_d, st_q, st_d;
  logic  [CNT_W-1:0]             rdata_q, rdata_d;

  logic [PG_W-1:0] page;
  logic [3:0]      off;
  logic            glb_sel;

  assign page    = bus_addr[ADDR_W-1:4];
  assign off     = bus_addr[3:0];
  assign glb_sel = (page == '0);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmr_channel #(
      .CNT_W(CNT_W), .PRE_W(PRE_W), .DRAIN_TICKS(DRAIN_TICKS)
    ) ch_i (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .en(ctrl_q[g].en), .reload(ctrl_q[g].reload),
      .oneshot(ctrl_q[g].oneshot), .pre(ctrl_q[g].pre),
      .interval(ival_q[g]), .cnt(cnt_w[g]), .act(act_w[g]),
      .ctick(ctick_w[g]), .hit(hit_w[g]), .rld_done(rld_w[g])
    );
  end

  // register next state
  always_comb begin
    ctrl_d = ctrl_q;
    ival_d = ival_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rld_w[i]) ctrl_d[i].reload = 1'b0;
      if (bus_wr && page == PG_W'(i + 1)) begin
        if (off == OFF_CTRL) ctrl_d[i] = ctrl_t'(bus_wdata[7:0]);
        if (off == OFF_IVAL) ival_d[i] = bus_wdata;
      end
    end
    ie_d = ie_q;
    if (bus_wr && glb_sel && off == OFF_IE) ie_d = bus_wdata[NUM_CH-1:0];
    st_d = st_q;
    if (bus_wr && glb_sel && off == OFF_ST) st_d = st_q & ~bus_wdata[NUM_CH-1:0];
    st_d = st_d | hit_w;
  end

  // read mux
  always_comb begin
    rdata_d = '0;
    if (bus_rd) begin
      if (glb_sel && off == OFF_IE) rdata_d = CNT_W'(ie_q);
      if (glb_sel && off == OFF_ST) rdata_d = CNT_W'(st_q);
      for (int i = 0; i < NUM_CH; i++) begin
        if (page == PG_W'(i + 1)) begin
          if (off == OFF_CTRL) rdata_d = CNT_W'(ctrl_q[i]);
          if (off == OFF_IVAL) rdata_d = ival_q[i];
          if (off == OFF_CNT)  rdata_d = cnt_w[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ival_q  <= '0;
      ie_q    <= '0;
      st_q    <= '0;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      ival_q  <= ival_d;
      ie_q    <= ie_d;
      st_q    <= st_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = |(st_q & ie_q);
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            irq,
  input logic  [NUM_CH-1:0]              ie_q,
  input logic  [NUM_CH-1:0]              st_q,
  input logic  [NUM_CH-1:0]              act_w,
  input logic  [NUM_CH-1:0]              ctick_w,
  input logic  [NUM_CH-1:0]              hit_w,
  input ctrl_t [NUM_CH-1:0]              ctrl_q,
  input logic  [NUM_CH-1:0][CNT_W-1:0]   ival_q,
  input logic  [NUM_CH-1:0][CNT_W-1:0]   cnt_w
);
  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == '0) |-> !irq);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_a
    // R9
    idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !act_w[g] |-> !ctick_w[g]);
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !act_w[g] |=> $stable(cnt_w[g]));
    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctick_w[g] && !ctrl_q[g].reload && cnt_w[g] != '0)
      |=> cnt_w[g] == $past(cnt_w[g]) - CNT_W'(1));
    // R5
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctick_w[g] && !ctrl_q[g].reload && ctrl_q[g].oneshot && cnt_w[g] == '0)
      |=> cnt_w[g] == '0);
    // R3
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctick_w[g] && ctrl_q[g].reload) |=> cnt_w[g] == $past(ival_q[g]));
    // R7
    hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_w[g] |=> st_q[g]);
  end
endmodule

bind evt_timer_top evt_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .ie_q(ie_q), .st_q(st_q),
  .act_w(act_w), .ctick_w(ctick_w), .hit_w(hit_w), .ctrl_q(ctrl_q),
  .ival_q(ival_q), .cnt_w(cnt_w)
);

// File: tb/evt_timer_top_tb_top.sv
module evt_timer_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic        clk, rst_n, tick, bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;
  logic [31:0] rv;

  evt_timer_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) begin
      failures = failures + 1;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic stop_ch(input logic [7:0] base);
    wr(base, 32'h0);
    ticks(2);
  endtask

  // periodic sweep on channel 0
  task automatic run_periodic(input int ival, input int p);
    int exp, prev;
    stop_ch(8'h10);
    wr(8'h04, 32'h1);
    wr(8'h14, 32'(ival));
    wr(8'h10, 32'h3 | 32'(p << 4));
    rd(8'h10, rv); chk("R3 reload pending", rv, 32'h3 | 32'(p << 4));
    prev = 0;
    for (int s = 0; s <= 2 * (ival + 1); s++) begin
      if (p > 0) begin
        ticks((1 << p) - 1);
        if (s > 0) begin
          rd(8'h18, rv); chk("R6 no step before divided tick", rv, 32'(prev));
        end
      end
      ticks(1);
      exp = ival - (s % (ival + 1));
      rd(8'h18, rv); chk("R4 periodic count", rv, 32'(exp));
      if (s == 0) begin
        rd(8'h10, rv); chk("R3 reload self-clears", rv, 32'h1 | 32'(p << 4));
      end
      rd(8'h04, rv); chk("R7 status on zero", rv & 32'h1, (exp == 0) ? 32'h1 : 32'h0);
      if (exp == 0) begin
        wr(8'h04, 32'h1);
        rd(8'h04, rv); chk("R7 write-one clear", rv & 32'h1, 32'h0);
      end
      prev = exp;
    end
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq low", {31'b0, irq}, 32'h0);
    foreach (rv[k]) begin end
    for (int a = 0; a < 11; a++) begin
      logic [7:0] ad;
      ad = 8'((a < 2) ? a * 4 : (a < 5 ? 8'h10 + (a - 2) * 4 : (a < 8 ? 8'h20 + (a - 5) * 4 : 8'h0C)));
      rd(ad, rv); chk("R1 reset value", rv, 32'h0);
    end

    // R2 / R10 / R11 map and readback
    wr(8'h14, 32'h1234_5678);
    rd(8'h14, rv); chk("R2 interval readback", rv, 32'h1234_5678);
    wr(8'h20, 32'hFFFF_FF7C);
    rd(8'h20, rv); chk("R2 R10 control fields readback", rv, 32'h0000_007C);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, rv); chk("R2 enable width", rv, 32'h3);
    wr(8'h00, 32'h0);
    wr(8'h20, 32'h0);
    wr(8'h0C, 32'hDEAD_BEEF);
    rd(8'h0C, rv); chk("R11 unmapped reads zero", rv, 32'h0);
    rd(8'h04, rv); chk("R11 unmapped write ignored", rv, 32'h0);

    // R4 R6 R7 sweep
    for (int p = 0; p < 3; p++) begin
      run_periodic(0, p);
      run_periodic(1, p);
      run_periodic(2, p);
      run_periodic(4, p);
    end

    // R5 one-shot
    stop_ch(8'h10); wr(8'h04, 32'h1);
    wr(8'h14, 32'd3); wr(8'h10, 32'h83);
    ticks(1); rd(8'h18, rv); chk("R5 one-shot load", rv, 32'd3);
    rd(8'h10, rv); chk("R3 one-shot reload cleared", rv, 32'h81);
    ticks(3); rd(8'h18, rv); chk("R5 one-shot reaches zero", rv, 32'd0);
    rd(8'h04, rv); chk("R5 one-shot status", rv, 32'h1);
    wr(8'h04, 32'h1);
    ticks(4); rd(8'h18, rv); chk("R5 one-shot holds zero", rv, 32'd0);
    rd(8'h04, rv); chk("R5 no second status", rv, 32'h0);

    // R8 interrupt masking
    stop_ch(8'h10); wr(8'h04, 32'h3);
    wr(8'h14, 32'd0); wr(8'h10, 32'h83); ticks(1);
    rd(8'h04, rv); chk("R7 zero-interval reload status", rv, 32'h1);
    chk("R8 masked irq", {31'b0, irq}, 32'h0);
    wr(8'h00, 32'h2); chk("R8 other enable irq", {31'b0, irq}, 32'h0);
    wr(8'h00, 32'h1); chk("R8 enabled irq", {31'b0, irq}, 32'h1);
    wr(8'h04, 32'h0); chk("R7 write zero keeps irq", {31'b0, irq}, 32'h1);
    wr(8'h04, 32'h1); chk("R8 irq drops on clear", {31'b0, irq}, 32'h0);
    wr(8'h00, 32'h0);

    // R7 set wins over simultaneous clear
    stop_ch(8'h10); wr(8'h04, 32'h3);
    wr(8'h14, 32'd2); wr(8'h10, 32'h83); ticks(2);
    rd(8'h18, rv); chk("R5 one-shot at one", rv, 32'd1);
    @(negedge clk); tick = 1'b1; bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h1;
    @(negedge clk); tick = 1'b0; bus_wr = 1'b0;
    rd(8'h04, rv); chk("R7 set beats clear", rv, 32'h1);
    wr(8'h04, 32'h1);

    // R9 drain after disable
    stop_ch(8'h10); wr(8'h04, 32'h3);
    wr(8'h14, 32'd100); wr(8'h10, 32'h03); ticks(11);
    rd(8'h18, rv); chk("R4 long run count", rv, 32'd90);
    wr(8'h10, 32'h0);
    ticks(1); rd(8'h18, rv); chk("R9 first drain tick", rv, 32'd89);
    ticks(1); rd(8'h18, rv); chk("R9 second drain tick", rv, 32'd88);
    ticks(3); rd(8'h18, rv); chk("R9 frozen after drain", rv, 32'd88);
    wr(8'h18, 32'h0000_ABCD);
    rd(8'h18, rv); chk("R11 count write ignored", rv, 32'd88);

    // R12 / R10 independence, prescale and source on channel 1
    wr(8'h04, 32'h3);
    wr(8'h14, 32'd20); wr(8'h24, 32'd2);
    wr(8'h10, 32'h03); wr(8'h20, 32'h1F);
    ticks(6);
    rd(8'h18, rv); chk("R12 channel 0 count", rv, 32'd15);
    rd(8'h28, rv); chk("R12 R6 channel 1 count", rv, 32'd0);
    rd(8'h04, rv); chk("R12 status of channel 1 only", rv, 32'h2);
    rd(8'h20, rv); chk("R10 source kept", rv, 32'h1D);
    ticks(2);
    rd(8'h28, rv); chk("R4 R12 channel 1 periodic reload", rv, 32'd2);
    rd(8'h18, rv); chk("R12 channel 0 unaffected", rv, 32'd13);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule